// File: doc/BRIEF.md
# BCD Real-Time Calendar Clock

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, day of month, month, a two-digit year and a weekday. The system clock runs it. A one-cycle enable pulse, `tick_in`, arrives once per second from a slow oscillator domain that has already been brought into the system clock domain. The block holds each tick for one cycle inside. Because of this it can raise a sync flag one cycle before the counters move, and keep it up through the update cycle.

Software reaches the block through a small register port with a combinational read path. There are three registers: control, time and date. To set the time, software clears the enable bit and polls the running status until it reads 0. It then loads time and date with the write-enable bit set, and finally sets enable again. Instead of stopping the clock, software can also write while the sync flag reads 0.

Address map: 0 is control, 1 is time, 2 is date. Address 3 reads as zero and ignores writes.

Top module: `rtc_bcd`

## Requirements
- R1: After reset, time reads 0x00000000, date reads 0x00010100 (year 00, January, day 01, weekday 0), and control reads 0.
- R2: The time register holds BCD hours in [31:24], minutes in [23:16] and seconds in [15:8], and reads zero in [7:0]. Seconds and minutes wrap from 0x59 to 0x00 and carry. Hours wrap from 0x23 to 0x00 and carry into the date.
- R3: The date register holds the BCD year in [31:24], month in [23:16], day in [15:8] and weekday in [7:0]. A day carry past the month's last day sets day to 0x01 and advances the month. April, June, September and November have 30 days. February has 29 days when the year value is divisible by 4 and 28 otherwise. All other months have 31 days. Month 0x12 wraps to 0x01 and advances the year, and year 0x99 wraps to 0x00.
- R4: The weekday advances on every hour carry, counts 0 to 6, and wraps to 0.
- R5: Control bit 15 (enable) and bit 3 (write enable) are read/write. Bit 6 (running) and bit 2 (sync) are read-only. All other control bits read 0, and writes to them or to address 3 have no effect.
- R6: Running changes only on the update cycle that follows a tick, where it takes the enable value. The counters advance one second on that update cycle only if running was already 1.
- R7: `sync_out` and control bit 2 are 1 in the cycle where `tick_in` is high and in the following cycle. They are 0 otherwise. The counters change at the clock edge that ends that following cycle.
- R8: A write to time or date takes effect only if write enable is 1 before the write cycle. Otherwise the register is left unchanged.
- R9: A time or date write that lands on an update cycle replaces the whole register, and that cycle's increment is discarded for that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| sync_out | output | 1 | Update window flag, same as control bit 2 |

## Verification
- **Reads and sync:** reads and `sync_out` are combinational. They are due in the same cycle as the address or tick that drives them.
- **Writes:** a register write shows up one cycle after its strobe.
- **Tick updates:** counter and running-status changes show up two cycles after `tick_in` goes high, because of the internal tick register plus the counter register.
- **How the checks keep to that:** inputs are driven 2 ns after a rising edge, and outputs are compared at the falling edge. A behavioural model that advances on the same edges is compared in every cycle. Directed checks then read each register once the pipeline above has settled.

// File: rtl/rtc_bcd.sv
module rtc_bcd #(
  parameter logic [7:0] WD_LAST = 8'd6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_in,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        sync_out
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TIME = 2'd1;
  localparam logic [1:0] A_DATE = 2'd2;

  logic       tick_q, on_q, wren_q, run_q;
  logic [7:0] sec, min, hr, day, mon, yr, wd;
  logic [7:0] sec_n, min_n, hr_n, day_n, mon_n, yr_n, wd_n, dlim;
  logic [6:0] yr_bin;
  logic       step, c_sec, c_min, c_hr, c_day, c_mon;
  logic       w_ctrl, w_time, w_date;
  logic [23:0] time_v;
  logic [31:0] date_v, ctrl_v;
  logic       unused_bits;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign yr_bin = {3'b0, yr[7:4]} * 7'd10 + {3'b0, yr[3:0]};

  always_comb begin
    case (mon)
      8'h02:                      dlim = (yr_bin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: dlim = 8'h30;
      default:                    dlim = 8'h31;
    endcase
  end

  assign step  = tick_q & run_q;
  assign c_sec = step  && sec >= 8'h59;
  assign c_min = c_sec && min >= 8'h59;
  assign c_hr  = c_min && hr  >= 8'h23;
  assign c_day = c_hr  && day >= dlim;
  assign c_mon = c_day && mon >= 8'h12;

  assign sec_n = !step  ? sec : c_sec ? 8'h00 : bcd_inc(sec);
  assign min_n = !c_sec ? min : c_min ? 8'h00 : bcd_inc(min);
  assign hr_n  = !c_min ? hr  : c_hr  ? 8'h00 : bcd_inc(hr);
  assign day_n = !c_hr  ? day : c_day ? 8'h01 : bcd_inc(day);
  assign mon_n = !c_day ? mon : c_mon ? 8'h01 : bcd_inc(mon);
  assign yr_n  = !c_mon ? yr  : (yr >= 8'h99) ? 8'h00 : bcd_inc(yr);
  assign wd_n  = !c_hr  ? wd  : (wd >= WD_LAST) ? 8'h00 : wd + 8'd1;

  assign w_ctrl = wr_en && wr_addr == A_CTRL;
  assign w_time = wr_en && wr_addr == A_TIME && wren_q;
  assign w_date = wr_en && wr_addr == A_DATE && wren_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      on_q   <= 1'b0;
      wren_q <= 1'b0;
      run_q  <= 1'b0;
      {hr, min, sec}      <= 24'h0;
      {yr, mon, day, wd}  <= 32'h0001_0100;
    end else begin
      tick_q <= tick_in;
      if (tick_q) run_q <= on_q;
      if (w_ctrl) begin
        on_q   <= wr_data[15];
        wren_q <= wr_data[3];
      end
      if (w_time) {hr, min, sec} <= wr_data[31:8];
      else        {hr, min, sec} <= {hr_n, min_n, sec_n};
      if (w_date) {yr, mon, day, wd} <= wr_data;
      else        {yr, mon, day, wd} <= {yr_n, mon_n, day_n, wd_n};
    end
  end

  assign sync_out = tick_in | tick_q;
  assign time_v   = {hr, min, sec};
  assign date_v   = {yr, mon, day, wd};
  assign ctrl_v   = {16'h0, on_q, 8'h0, run_q, 2'b0, wren_q, sync_out, 2'b0};

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = ctrl_v;
      A_TIME:  rd_data = {time_v, 8'h00};
      A_DATE:  rd_data = date_v;
      default: rd_data = 32'h0;
    endcase
  end

  assign unused_bits = ^{wr_data[7:0]};
endmodule

// File: rtl/rtc_bcd_chk.sv
module rtc_bcd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_in,
  input logic        tick_q,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic        wren_q,
  input logic        on_q,
  input logic        run_q,
  input logic [23:0] time_v,
  input logic [31:0] date_v,
  input logic        sync_out
);
  p_run_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_q |=> $stable(run_q));

  p_run_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> run_q == $past(on_q));

  p_sync_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_in |=> sync_out);

  p_sync_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_in && !$past(tick_in)) |-> !sync_out);

  p_time_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_q && !(wr_en && wr_addr == 2'd1)) |=> $stable(time_v));

  p_time_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && !wren_q && !tick_q) |=> $stable(time_v));

  p_date_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && !wren_q && !tick_q) |=> $stable(date_v));

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && run_q && time_v[7:0] == 8'h59 && !(wr_en && wr_addr == 2'd1 && wren_q))
      |=> time_v[7:0] == 8'h00);
endmodule

bind rtc_bcd rtc_bcd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tick_q(tick_q),
  .wr_en(wr_en), .wr_addr(wr_addr), .wren_q(wren_q), .on_q(on_q),
  .run_q(run_q), .time_v(time_v), .date_v(date_v), .sync_out(sync_out)
);

// File: tb/rtc_bcd_bench.sv
module rtc_bcd_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, tick_in = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0, rd_addr = 2'd1;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data;
  logic        sync_out;

  rtc_bcd u_rtc_bcd (.clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sync_out(sync_out));

  int checks = 0, errors = 0;
  bit done = 0;
  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_wd;
  bit m_on, m_wren, m_run, m_tq;

  function automatic logic [7:0] bcd(int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction
  function automatic int unb(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return (32'(m_on) << 15) | (32'(m_run) << 6) | (32'(m_wren) << 3)
                 | (32'(tick_in | m_tq) << 2);
      2'd1: return {bcd(m_hr), bcd(m_min), bcd(m_sec), 8'h00};
      2'd2: return {bcd(m_yr), bcd(m_mon), bcd(m_day), bcd(m_wd)};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_wd = 0;
      m_on = 0; m_wren = 0; m_run = 0; m_tq = 0;
    end else begin
      bit old_wren;
      old_wren = m_wren;
      if (m_tq && m_run) begin
        m_sec++;
        if (m_sec == 60) begin
          m_sec = 0; m_min++;
          if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin
              m_hr = 0; m_wd = (m_wd + 1) % 7; m_day++;
              if (m_day > mdays(m_mon, m_yr)) begin
                m_day = 1; m_mon++;
                if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
              end
            end
          end
        end
      end
      if (m_tq) m_run = m_on;
      if (wr_en) begin
        if (wr_addr == 2'd0) begin m_on = wr_data[15]; m_wren = wr_data[3]; end
        if (wr_addr == 2'd1 && old_wren) begin
          m_hr = unb(wr_data[31:24]); m_min = unb(wr_data[23:16]); m_sec = unb(wr_data[15:8]);
        end
        if (wr_addr == 2'd2 && old_wren) begin
          m_yr = unb(wr_data[31:24]); m_mon = unb(wr_data[23:16]);
          m_day = unb(wr_data[15:8]); m_wd = unb(wr_data[7:0]);
        end
      end
      m_tq = tick_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(rd_addr == 2'd1 ? "R2 model" : rd_addr == 2'd2 ? "R3 model" : "R5 model",
        rd_data, m_read(rd_addr));
    chk("R7 model sync", 32'(sync_out), 32'(tick_in | m_tq));
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #2; wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #2; wr_en = 0;
  endtask
  task automatic tick();
    @(posedge clk); #2; tick_in = 1;
    @(posedge clk); #2; tick_in = 0;
    repeat (3) @(posedge clk);
  endtask
  task automatic expect_reg(input logic [1:0] a, input logic [31:0] v, input string tag);
    @(posedge clk); #2; rd_addr = a;
    @(negedge clk); chk(tag, rd_data, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1;
    expect_reg(2'd0, 32'h0, "R1 ctrl");
    expect_reg(2'd1, 32'h0, "R1 time");
    expect_reg(2'd2, 32'h0001_0100, "R1 date");

    wr(2'd1, 32'h1234_5600);
    expect_reg(2'd1, 32'h0, "R8 locked time");
    wr(2'd2, 32'h0906_1502);
    expect_reg(2'd2, 32'h0001_0100, "R8 locked date");

    wr(2'd0, 32'h0000_0008);
    tick();
    expect_reg(2'd1, 32'h0, "R6 stopped no advance");
    wr(2'd1, 32'h2359_58AA);
    wr(2'd2, 32'h0402_2806);
    expect_reg(2'd1, 32'h2359_5800, "R2 loaded low byte zero");
    wr(2'd0, 32'h0000_8008);
    expect_reg(2'd0, 32'h0000_8008, "R6 enable before tick");
    tick();
    expect_reg(2'd0, 32'h0000_8048, "R6 running after tick");
    expect_reg(2'd1, 32'h2359_5800, "R6 start tick no advance");
    tick();
    expect_reg(2'd1, 32'h2359_5900, "R2 second step");
    tick();
    expect_reg(2'd1, 32'h0000_0000, "R2 midnight wrap");
    expect_reg(2'd2, 32'h0402_2900, "R3 leap Feb 29 R4 weekday wrap");

    wr(2'd0, 32'h0000_0008);
    expect_reg(2'd0, 32'h0000_0048, "R6 still running until tick");
    tick();
    expect_reg(2'd0, 32'h0000_0008, "R6 stopped");
    expect_reg(2'd1, 32'h0000_0100, "R6 last advance");
    wr(2'd1, 32'h2359_5900);
    wr(2'd2, 32'h0502_2802);
    wr(2'd0, 32'h0000_8008);
    tick(); tick();
    expect_reg(2'd2, 32'h0503_0103, "R3 plain Feb 28 to Mar 1 R4");

    wr(2'd1, 32'h2359_5900);
    wr(2'd2, 32'h9912_3106);
    tick();
    expect_reg(2'd2, 32'h0001_0100, "R3 year wrap R4");
    wr(2'd1, 32'h2359_5900);
    wr(2'd2, 32'h0004_3005);
    tick();
    expect_reg(2'd2, 32'h0005_0106, "R3 April 30 days");

    @(posedge clk); #2; tick_in = 1; rd_addr = 2'd0;
    @(negedge clk); chk("R7 sync lead", {31'h0, sync_out}, 32'h1);
    chk("R7 ctrl bit 2", rd_data & 32'h4, 32'h4);
    @(posedge clk); #2; tick_in = 0;
    wr_en = 1; wr_addr = 2'd1; wr_data = 32'h1122_3300;
    @(negedge clk); chk("R7 sync update cycle", {31'h0, sync_out}, 32'h1);
    @(posedge clk); #2; wr_en = 0;
    @(negedge clk); chk("R7 sync low", {31'h0, sync_out}, 32'h0);
    expect_reg(2'd1, 32'h1122_3300, "R9 write wins");

    wr(2'd0, 32'hFFFF_FFFF);
    expect_reg(2'd0, 32'h0000_8048, "R5 read-only bits");
    wr(2'd3, 32'hFFFF_FFFF);
    expect_reg(2'd3, 32'h0, "R5 spare address");
    wr(2'd0, 32'h0000_8000);
    wr(2'd1, 32'h0101_0100);
    expect_reg(2'd1, 32'h1122_3300, "R8 relocked");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule